// File: doc/BRIEF.md
# DisplayPort PHY Test Pattern Generator

This block produces the four-lane, 10-bit-per-lane symbol stream that a DisplayPort transmitter puts on its lanes in place of link data during compliance and debug runs. A small write-only control port sets the mode. In bypass mode each lane carries one of three sources. The first is the stored 80-bit pattern, played as eight 10-bit symbols. The second is a PRBS7 sequence. The third is a symbol-error-measurement sequence. The stored pattern covers the D10.2 clock pattern (all eight symbols 0x2AA) as well as any user pattern. When bypass is clear, the generator does not drive the lanes. It only presents the selected training-pattern index to the link layer, which produces training patterns 1 to 4 itself.

The symbol output is a valid/ready stream. `sym_valid` is high exactly while live bypass is set. A beat is accepted when `sym_valid && sym_ready`. While `sym_ready` is low, `sym_data` holds and neither the symbol phase nor the PRBS state moves. Every control write first lands in a shadow copy. The shadow is copied to the live copy at an 8-symbol boundary, so a half-written pattern never reaches the lanes.

Top module: `dp_phy_patgen`

## Requirements
- R1: After reset, `sym_valid`=0, `sym_data`=0, `train_sel`=0 and `link_trained`=0. All stored symbols and mode bits are zero.
- R2: A write changes only the shadow copy. The shadow is copied to the live copy on the clock edge after any cycle in which live bypass is 0. It is also copied on the edge that accepts the beat with phase 7. The copy moves the shadow as it was before any write in that same cycle.
- R3: The stored pattern is an 80-bit vector in which symbol k occupies bits [10k+9:10k]. Address 1 writes symbols 0..2 from wdata[29:0]. Address 2 writes symbols 3..5 from wdata[29:0]. Address 3 writes symbols 6..7 from wdata[19:0].
- R4: Address 5 loads one pattern byte, wdata[7:0], at byte index wdata[11:8] into vector bits [8i+7:8i]. This packs ten bytes least-significant-bit first into the eight symbols. An index of 10 or more is ignored.
- R5: The phase starts at 0 when bypass goes live. It advances by one, modulo 8, on each accepted beat and holds otherwise. A lane whose select bit is set outputs stored symbol[phase]. `sym_data` and `sym_valid` hold while `sym_ready` is low.
- R6: Address 0 sets the mode: bit 0 bypass, bit 1 PRBS enable, bit 2 PRBS select, bits 7:4 lane select (bit 4+l for lane l). With PRBS enabled and select 0, a lane with its select bit clear carries PRBS7 from x^7+x^6+1. Each step outputs b=s[6]^s[5] and shifts s to {s[5:0],b}. Symbol bit j is step j. The state advances 10 steps per accepted beat.
- R7: With PRBS enabled and select 1, a PRBS lane carries the PRBS7 symbol at phases 0..6 and the marker 0x17C at phase 7. The PRBS state advances on every accepted beat, including phase 7.
- R8: A lane with its select bit clear and PRBS disabled outputs 0x000 while valid.
- R9: A write to address 4 sets the training index to wdata[1:0] (training patterns 1..4), shown on `train_sel`. The same write clears bypass, PRBS enable and training-complete in the shadow.
- R10: While `sym_valid` is 0, `sym_data` is all zeros. Lane l occupies `sym_data[10l+9:10l]`.
- R11: Address 6 bit 0 sets training-complete, shown on `link_trained` once live.
- R12: The PRBS state is reloaded with all ones when a copy turns PRBS on or changes its select. It never becomes zero, so no PRBS symbol is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 3 | Control register address |
| cfg_wdata | input | 30 | Control write data |
| sym_valid | output | 1 | Symbol beat valid (live bypass) |
| sym_ready | input | 1 | Downstream accepts the beat |
| sym_data | output | 40 | Four lanes of 10-bit symbols, lane 0 lowest |
| train_sel | output | 2 | Live training-pattern index |
| link_trained | output | 1 | Live training-complete flag |

## Verification
A control write and a boundary copy can fall in the same cycle. The write must then stay in the shadow while the copy takes the older shadow contents. The bench provokes this by issuing random writes during long bypass runs with random back-pressure, so some writes land exactly on the accepted phase-7 beat. A reference model in the bench applies the copy before the write. Every cycle it compares all four lanes, `sym_valid`, `train_sel` and `link_trained` against that model. A second overlap is a PRBS reseed coinciding with a phase-7 advance. The model resolves it in favour of the reseed.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  localparam int LANES  = 4;
  localparam int SYM_W  = 10;
  localparam int NSYM   = 8;
  localparam int PH_W   = $clog2(NSYM);
  localparam int PAT_W  = NSYM * SYM_W;
  localparam int NBYTES = PAT_W / 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 30;
  localparam int LFSR_W = 7;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SYMA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SYMB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SYMC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRAIN = 3'd4;
  localparam logic [ADDR_W-1:0] A_BYTE  = 3'd5;
  localparam logic [ADDR_W-1:0] A_LINK  = 3'd6;

  typedef struct packed {
    logic             bypass;
    logic             prbs_en;
    logic             prbs_sel;
    logic [LANES-1:0] lane_sel;
    logic [1:0]       tp_idx;
    logic             trained;
    logic [PAT_W-1:0] syms;
  } cfg_t;
endpackage

// File: rtl/dpp_regs.sv
module dpp_regs
  import dpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  output cfg_t              live,
  output logic [PH_W-1:0]   phase,
  output logic              seed
);
  localparam int SEG3 = 3 * SYM_W;
  localparam int SEG2 = 2 * SYM_W;

  cfg_t shadow;
  logic commit;
  logic [3:0] byte_idx;

  assign byte_idx = wdata[11:8];
  assign commit = !live.bypass || (fire && phase == PH_W'(NSYM-1));
  assign seed = commit && shadow.prbs_en &&
                (!live.prbs_en || (shadow.prbs_sel != live.prbs_sel));

  // shadow register set, written by the control port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (we) begin
      case (addr)
        A_MODE: begin
          shadow.bypass   <= wdata[0];
          shadow.prbs_en  <= wdata[1];
          shadow.prbs_sel <= wdata[2];
          shadow.lane_sel <= wdata[4 +: LANES];
        end
        A_SYMA: shadow.syms[0      +: SEG3] <= wdata[SEG3-1:0];
        A_SYMB: shadow.syms[SEG3   +: SEG3] <= wdata[SEG3-1:0];
        A_SYMC: shadow.syms[2*SEG3 +: SEG2] <= wdata[SEG2-1:0];
        A_TRAIN: begin
          shadow.tp_idx  <= wdata[1:0];
          shadow.bypass  <= 1'b0;
          shadow.prbs_en <= 1'b0;
          shadow.trained <= 1'b0;
        end
        A_BYTE: begin
          if (32'(byte_idx) < NBYTES)
            shadow.syms[byte_idx*8 +: 8] <= wdata[7:0];
        end
        A_LINK: shadow.trained <= wdata[0];
        default: ;
      endcase
    end
  end

  // live set and symbol phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= '0;
      phase <= '0;
    end else begin
      if (commit)
        live <= shadow;
      if (!live.bypass)
        phase <= '0;
      else if (fire)
        phase <= phase + 1'b1;
    end
  end

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live.bypass && !(fire && phase == PH_W'(NSYM-1))) |=> $stable(live));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live.bypass && !fire) |=> $stable(phase));
endmodule

// File: rtl/dpp_prbs.sv
module dpp_prbs
  import dpp_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed,
  input  logic             advance,
  output logic [SYM_W-1:0] sym
);
  logic [LFSR_W-1:0] lfsr, nxt;

  // ten serial steps of x^7 + x^6 + 1 per symbol, LSB first
  always_comb begin
    logic [LFSR_W-1:0] s;
    logic b;
    s = lfsr;
    sym = '0;
    for (int j = 0; j < SYM_W; j++) begin
      b = s[6] ^ s[5];
      sym[j] = b;
      s = {s[5:0], b};
    end
    nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr <= SEED;
    else if (seed)    lfsr <= SEED;
    else if (advance) lfsr <= nxt;
  end

  // R12
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: rtl/dpp_lane.sv
module dpp_lane
  import dpp_pkg::*;
#(
  parameter int               LANE_IDX = 0,
  parameter logic [SYM_W-1:0] MARKER   = 10'h17C
) (
  input  cfg_t             live,
  input  logic [PH_W-1:0]  phase,
  input  logic [SYM_W-1:0] prbs_sym,
  output logic [SYM_W-1:0] sym
);
  logic [SYM_W-1:0] stored;
  assign stored = live.syms[phase*SYM_W +: SYM_W];

  always_comb begin
    if (!live.bypass)
      sym = '0;
    else if (live.lane_sel[LANE_IDX])
      sym = stored;
    else if (live.prbs_en)
      sym = (live.prbs_sel && phase == PH_W'(NSYM-1)) ? MARKER : prbs_sym;
    else
      sym = '0;
  end
endmodule

// File: rtl/dp_phy_patgen.sv
module dp_phy_patgen
  import dpp_pkg::*;
#(
  parameter logic [SYM_W-1:0]  MARKER = 10'h17C,
  parameter logic [LFSR_W-1:0] SEED   = 7'h7F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic                   sym_valid,
  input  logic                   sym_ready,
  output logic [LANES*SYM_W-1:0] sym_data,
  output logic [1:0]             train_sel,
  output logic                   link_trained
);
  cfg_t             live;
  logic [PH_W-1:0]  phase;
  logic             seed, fire;
  logic [SYM_W-1:0] prbs_sym;

  assign sym_valid    = live.bypass;
  assign fire         = sym_valid && sym_ready;
  assign train_sel    = live.tp_idx;
  assign link_trained = live.trained;

  dpp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .fire(fire), .live(live), .phase(phase), .seed(seed)
  );

  dpp_prbs #(.SEED(SEED)) u_prbs (
    .clk(clk), .rst_n(rst_n), .seed(seed),
    .advance(fire && live.prbs_en), .sym(prbs_sym)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dpp_lane #(.LANE_IDX(l), .MARKER(MARKER)) u_lane (
      .live(live), .phase(phase), .prbs_sym(prbs_sym),
      .sym(sym_data[l*SYM_W +: SYM_W])
    );
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> sym_data == '0);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));
endmodule

// File: tb/tb_dp_phy_patgen.sv
module tb_dp_phy_patgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [29:0] cfg_wdata = '0;
  logic        sym_ready = 1'b0;
  logic        sym_valid;
  logic [39:0] sym_data;
  logic [1:0]  train_sel;
  logic        link_trained;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dp_phy_patgen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .train_sel(train_sel), .link_trained(link_trained)
  );

  // reference model: shadow (s_) and live (l_) copies
  logic       s_byp, s_pen, s_psel, s_trn, l_byp, l_pen, l_psel, l_trn;
  logic [3:0] s_lsel, l_lsel;
  logic [1:0] s_tp, l_tp;
  logic [79:0] s_pat, l_pat;
  logic [2:0] m_ph;
  logic [6:0] m_lfsr;
  logic [7:0] bytes [10];

  function automatic logic [9:0] prbs_sym(input logic [6:0] st);
    logic [9:0] r;
    for (int j = 0; j < 10; j++) begin
      r[j] = st[6] ^ st[5];
      st = {st[5:0], r[j]};
    end
    return r;
  endfunction

  function automatic logic [6:0] prbs_adv(input logic [6:0] st);
    for (int j = 0; j < 10; j++) st = {st[5:0], st[6] ^ st[5]};
    return st;
  endfunction

  function automatic logic [9:0] exp_lane(input int l);
    if (!l_byp) return 10'h000;
    if (l_lsel[l]) return l_pat[m_ph*10 +: 10];
    if (l_pen) return (l_psel && m_ph == 3'd7) ? 10'h17C : prbs_sym(m_lfsr);
    return 10'h000;
  endfunction

  // packing written byte-wise, R4
  function automatic logic [9:0] packed_sym(input int k);
    int g, b;
    g = k / 4;
    b = 5 * g;
    case (k % 4)
      0: return {bytes[b+1][1:0], bytes[b]};
      1: return {bytes[b+2][3:0], bytes[b+1][7:2]};
      2: return {bytes[b+3][5:0], bytes[b+2][7:4]};
      default: return {bytes[b+4], bytes[b+3][7:6]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic fire, commit, seed;
    fire   = l_byp && sym_ready;
    commit = !l_byp || (fire && m_ph == 3'd7);
    seed   = commit && s_pen && (!l_pen || s_psel != l_psel);
    if (seed) m_lfsr = 7'h7F;
    else if (fire && l_pen) m_lfsr = prbs_adv(m_lfsr);
    if (!l_byp) m_ph = 3'd0; else if (fire) m_ph = m_ph + 3'd1;
    if (commit) begin
      l_byp = s_byp; l_pen = s_pen; l_psel = s_psel; l_lsel = s_lsel;
      l_tp = s_tp; l_trn = s_trn; l_pat = s_pat;
    end
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: begin s_byp = cfg_wdata[0]; s_pen = cfg_wdata[1];
                    s_psel = cfg_wdata[2]; s_lsel = cfg_wdata[7:4]; end
        3'd1: s_pat[29:0]  = cfg_wdata;
        3'd2: s_pat[59:30] = cfg_wdata;
        3'd3: s_pat[79:60] = cfg_wdata[19:0];
        3'd4: begin s_tp = cfg_wdata[1:0]; s_byp = 1'b0; s_pen = 1'b0; s_trn = 1'b0; end
        3'd5: if (cfg_wdata[11:8] < 4'd10) s_pat[cfg_wdata[11:8]*8 +: 8] = cfg_wdata[7:0];
        3'd6: s_trn = cfg_wdata[0];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    string tag;
    logic [39:0] e;
    for (int l = 0; l < 4; l++) e[l*10 +: 10] = exp_lane(l);
    if (!l_byp) tag = "R10";
    else if (l_pen) tag = l_psel ? "R7" : "R6";
    else if (l_lsel != 4'h0) tag = "R5/R3";
    else tag = "R8";
    check(tag, sym_data, e);
    check("R2 valid", {39'd0, sym_valid}, {39'd0, l_byp});
    check("R9 train_sel", {38'd0, train_sel}, {38'd0, l_tp});
    check("R11 link_trained", {39'd0, link_trained}, {39'd0, l_trn});
    if (l_byp && l_pen && !(l_psel && m_ph == 3'd7))
      for (int l = 0; l < 4; l++)
        if (!l_lsel[l]) check("R12 nonzero", {39'd0, sym_data[l*10 +: 10] != 10'h0}, 40'd1);
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [29:0] d, input logic rdy);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; sym_ready = rdy;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [29:0] d);
    cyc(1'b1, a, d, 1'b1);
  endtask

  task automatic run(input int n, input int ready_pct);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 30'd0, ($urandom % 100) < ready_pct);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    s_byp = 0; s_pen = 0; s_psel = 0; s_trn = 0; s_lsel = 0; s_tp = 0; s_pat = 0;
    l_byp = 0; l_pen = 0; l_psel = 0; l_trn = 0; l_lsel = 0; l_tp = 0; l_pat = 0;
    m_ph = 0; m_lfsr = 7'h7F;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", sym_data, 40'd0);
    check("R1 ctl", {36'd0, sym_valid, train_sel, link_trained}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // D10.2 on all lanes, R3
    wr(3'd1, {3{10'h2AA}}); wr(3'd2, {3{10'h2AA}}); wr(3'd3, {2{10'h2AA}});
    wr(3'd0, 30'h0F1);
    run(3, 100);
    check("R3 d102", sym_data, {4{10'h2AA}});
    run(20, 60);

    // byte-packed custom pattern, R4; leave bypass first
    wr(3'd4, 30'd2);
    run(2, 100);
    for (int i = 0; i < 10; i++) begin
      bytes[i] = 8'($urandom);
      wr(3'd5, {18'd0, 4'(i), bytes[i]});
    end
    wr(3'd5, {18'd0, 4'd12, 8'hFF}); // R4 ignored index
    wr(3'd0, 30'h0F1);
    for (int i = 0; i < 24; i++) begin
      cyc(1'b0, 3'd0, 30'd0, 1'b1);
      if (sym_valid) check("R4 packing", {30'd0, sym_data[9:0]}, {30'd0, packed_sym(m_ph)});
    end

    // PRBS7 on lanes 1,3, stored on 0,2
    wr(3'd6, 30'd1);
    wr(3'd0, 30'h053);
    run(40, 70);
    // symbol-error mode, all PRBS lanes
    wr(3'd0, 30'h007);
    run(40, 70);
    // R8 idle lanes
    wr(3'd0, 30'h031);
    run(20, 100);
    // R9 training select clears bypass
    wr(3'd6, 30'd1);
    run(10, 100);
    wr(3'd4, 30'd3);
    run(12, 100);
    check("R9 cleared", {37'd0, sym_valid, link_trained, 1'b0}, 40'd0);
    check("R9 idx", {38'd0, train_sel}, 40'd3);

    // random mix, writes sometimes on boundary beats
    for (int i = 0; i < 5000; i++) begin
      logic [2:0] a;
      logic [29:0] d;
      a = 3'($urandom % 7);
      d = 30'($urandom);
      if (a == 3'd0) d[0] = ($urandom % 4) != 0;
      if (a == 3'd4 && ($urandom % 3) != 0) a = 3'd0;
      if (a == 3'd5) d[11:8] = 4'($urandom % 12);
      cyc(($urandom % 12) == 0, a, d, ($urandom % 100) < 75);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule